// File: doc/BRIEF.md
# Event Timer Register File

This block is the software-visible register file of a multi-timer event timer. A requester presents an address, a byte count (1, 2, 4 or 8) and, for stores, write data. The block checks the access, finds the 64-bit register it falls in, and answers one cycle later. A load returns the addressed bytes right-justified. A store merges its bytes into the old register value, then keeps every bit that the register does not allow software to change.

The block holds these registers:

- a read-only capability word;
- a two-bit global configuration;
- a 64-bit free-running up-counter, gated by the global enable;
- for each timer, a configuration word, a comparator and a route word, spaced 0x20 bytes apart.

Neighbouring logic reads the counter value, the enable and the legacy-routing select from dedicated outputs. Comparator matching and interrupt delivery live outside this block.

Top module: `tmr_regfile`

## Requirements
- R1: An access is rejected when its byte count is not 1, 2, 4 or 8, or when its address is not a multiple of its byte count. A rejected access returns rsp_err=1 and rsp_rdata all ones, and changes no register.
- R2: A load returns the aligned 64-bit register shifted right by 8 times address bits 2:0, masked to the byte count. A store returns zero data.
- R3: A store of fewer than 8 bytes replaces only the byte lanes it covers. All other lanes keep their old value before the register's own mask is applied.
- R4: In the global configuration word at offset 0x010, only bits 1:0 are writable. Bit 0 drives glb_en_o and bit 1 drives legacy_o.
- R5: In each timer configuration word, only the bits in 0x3F4E are writable. The word resets to {ROUTE_CAP, 32'h0000_0030}.
- R6: The capability word at offset 0x000 reads {TICK_FS, 16'h8086, 1'b1, 1'b0, 1'b1, 5'(NUM_TMR-1), 8'h01}. With the defaults this is 64'h003D0900_8086A201. The word cannot be changed.
- R7: Timer n has its configuration word at 0x100+0x20n, its comparator at 0x108+0x20n and its route word at 0x110+0x20n. The route word is fully writable. Any offset at or above 0x100+0x20*NUM_TMR reads zero, and so does every unmapped offset below it.
- R8: The counter at offset 0x0F0 (cnt_o) adds one per clock while global bit 0 is set, and holds otherwise. A store to it always takes effect, even while counting, and wins over the increment in that cycle.
- R9: Stores to the capability word, to reserved offsets and to offsets past the last timer have no effect.
- R10: After reset the global word, the counter and the route words are zero, and every comparator is all ones.
- R11: While timer configuration bit 8 is set, a comparator store keeps only its low 32 bits and the upper half reads zero. Setting bit 8 clears the comparator's upper half.
- R12: Each accepted request cycle produces exactly one response cycle (rsp_valid) on the next clock. There is no response without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address within the register window |
| req_len | input | 4 | Byte count of the access |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Load data, right-justified |
| cnt_o | output | 64 | Current counter value |
| glb_en_o | output | 1 | Global enable bit |
| legacy_o | output | 1 | Legacy routing select bit |

## Verification
Loads use every byte count at several offsets within the capability word, which tells lane extraction apart from shift-amount and mask-width errors. Single-byte, half-word and word stores into one comparator, followed by a full read-back, show whether untouched lanes survive the merge. All-ones stores into configuration words show whether each register's writable mask is separate from the merge. Misaligned and odd-length accesses, counting over a known number of cycles, and counter stores made while counting each tell the error path, the enable gating and the write-over-increment priority apart.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

    localparam int unsigned REG_W = 64;
    localparam logic [REG_W-1:0] GCFG_WMASK = 64'h0000_0000_0000_0003;
    localparam logic [REG_W-1:0] TCFG_WMASK = 64'h0000_0000_0000_3F4E;
    localparam int unsigned TCFG_MODE32_BIT = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCFG,
        SEL_CNT,
        SEL_TCFG,
        SEL_TCMP,
        SEL_TRTE
    } reg_sel_e;

    function automatic logic [REG_W-1:0] lanes_to_bits(input logic [7:0] lanes);
        logic [REG_W-1:0] r;
        for (int b = 0; b < 8; b++) begin
            r[8*b +: 8] = {8{lanes[b]}};
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] keep_masked(input logic [REG_W-1:0] nval,
                                                     input logic [REG_W-1:0] oval,
                                                     input logic [REG_W-1:0] mask);
        return (nval & mask) | (oval & ~mask);
    endfunction

endpackage

// File: rtl/tmr_acc_decode.sv
module tmr_acc_decode
    import tmr_regs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned NUM_TMR = 3,
    localparam int unsigned IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        len,
    output logic              bad,
    output logic [2:0]        off,
    output logic [REG_W-1:0]  lane_m,
    output logic [REG_W-1:0]  size_m,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  tidx
);

    localparam int unsigned WORD_W   = ADDR_W - 3;
    localparam int unsigned W_CAP    = 0;
    localparam int unsigned W_GCFG   = 2;
    localparam int unsigned W_CNT    = 30;
    localparam int unsigned W_TBASE  = 32;
    localparam int unsigned W_TEND   = W_TBASE + 4 * NUM_TMR;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] rel;
    logic [7:0]        size_b;
    logic              len_ok;

    always_comb begin
        word   = addr[ADDR_W-1:3];
        off    = addr[2:0];
        len_ok = (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
        bad    = !len_ok || ((addr[2:0] & (len[2:0] - 3'd1)) != 3'd0);

        case (len)
            4'd1:    size_b = 8'h01;
            4'd2:    size_b = 8'h03;
            4'd4:    size_b = 8'h0F;
            4'd8:    size_b = 8'hFF;
            default: size_b = 8'h00;
        endcase
        size_m = lanes_to_bits(size_b);
        lane_m = lanes_to_bits(size_b << off);

        rel  = word - WORD_W'(W_TBASE);
        tidx = IDX_W'(rel >> 2);
        sel  = SEL_NONE;
        if (word == WORD_W'(W_CAP)) begin
            sel = SEL_CAP;
        end else if (word == WORD_W'(W_GCFG)) begin
            sel = SEL_GCFG;
        end else if (word == WORD_W'(W_CNT)) begin
            sel = SEL_CNT;
        end else if (word >= WORD_W'(W_TBASE) && word < WORD_W'(W_TEND)) begin
            case (rel[1:0])
                2'd0:    sel = SEL_TCFG;
                2'd1:    sel = SEL_TCMP;
                2'd2:    sel = SEL_TRTE;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tmr_timer_slot.sv
module tmr_timer_slot
    import tmr_regs_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic             wr_cmp,
    input  logic             wr_rte,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_o,
    output logic [REG_W-1:0] cmp_o,
    output logic [REG_W-1:0] rte_o
);

    localparam logic [REG_W-1:0] CFG_RST = {ROUTE_CAP, 32'h0000_0030};

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] cmp;
        logic [REG_W-1:0] rte;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_cfg) begin
            s_d.cfg = keep_masked(wdata, s_q.cfg, TCFG_WMASK);
            if (s_d.cfg[TCFG_MODE32_BIT]) begin
                s_d.cmp[REG_W-1:32] = '0;
            end
        end
        if (wr_cmp) begin
            s_d.cmp = s_q.cfg[TCFG_MODE32_BIT] ? {32'h0, wdata[31:0]} : wdata;
        end
        if (wr_rte) begin
            s_d.rte = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg <= CFG_RST;
            s_q.cmp <= '1;
            s_q.rte <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o = s_q.cfg;
    assign cmp_o = s_q.cmp;
    assign rte_o = s_q.rte;

    // R5: bits outside the writable mask never move on a config store
    a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> ((s_q.cfg & ~TCFG_WMASK) == ($past(s_q.cfg) & ~TCFG_WMASK)));

    // R11: 32-bit mode keeps the comparator upper half at zero
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg[TCFG_MODE32_BIT] |-> (s_q.cmp[REG_W-1:32] == 32'h0));

    // R9: comparator only changes on a comparator or config store
    a_r9_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cmp && !wr_cfg) |=> (s_q.cmp == $past(s_q.cmp)));

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_TMR   = 3,
    parameter logic [31:0] TICK_FS   = 32'd4000000,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_len,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic [63:0]       cnt_o,
    output logic              glb_en_o,
    output logic              legacy_o
);

    localparam int unsigned IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
    localparam logic [REG_W-1:0] CAP_VAL =
        {TICK_FS, 16'h8086, 1'b1, 1'b0, 1'b1, 5'(NUM_TMR - 1), 8'h01};

    typedef struct packed {
        logic [1:0]       gcfg;
        logic [REG_W-1:0] cnt;
        logic             rsp_valid;
        logic             rsp_err;
        logic [REG_W-1:0] rsp_data;
    } top_t;

    top_t n_d, n_q;

    logic             dec_bad;
    logic [2:0]       dec_off;
    logic [REG_W-1:0] dec_lane;
    logic [REG_W-1:0] dec_size;
    reg_sel_e         dec_sel;
    logic [IDX_W-1:0] dec_tidx;

    logic [REG_W-1:0] t_cfg [NUM_TMR];
    logic [REG_W-1:0] t_cmp [NUM_TMR];
    logic [REG_W-1:0] t_rte [NUM_TMR];
    logic [NUM_TMR-1:0] wr_cfg_v, wr_cmp_v, wr_rte_v;

    logic             wr_ok;
    logic             cnt_wr;
    logic             gcfg_wr;
    logic [REG_W-1:0] rd_full;
    logic [REG_W-1:0] merged;

    tmr_acc_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_TMR (NUM_TMR)
    ) i_dec (
        .addr   (req_addr),
        .len    (req_len),
        .bad    (dec_bad),
        .off    (dec_off),
        .lane_m (dec_lane),
        .size_m (dec_size),
        .sel    (dec_sel),
        .tidx   (dec_tidx)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_slot
        tmr_timer_slot #(
            .ROUTE_CAP (ROUTE_CAP)
        ) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_cfg (wr_cfg_v[t]),
            .wr_cmp (wr_cmp_v[t]),
            .wr_rte (wr_rte_v[t]),
            .wdata  (merged),
            .cfg_o  (t_cfg[t]),
            .cmp_o  (t_cmp[t]),
            .rte_o  (t_rte[t])
        );
    end

    always_comb begin
        case (dec_sel)
            SEL_CAP:  rd_full = CAP_VAL;
            SEL_GCFG: rd_full = {62'h0, n_q.gcfg};
            SEL_CNT:  rd_full = n_q.cnt;
            SEL_TCFG: rd_full = t_cfg[dec_tidx];
            SEL_TCMP: rd_full = t_cmp[dec_tidx];
            SEL_TRTE: rd_full = t_rte[dec_tidx];
            default:  rd_full = '0;
        endcase

        merged  = ((req_wdata << {dec_off, 3'b000}) & dec_lane) | (rd_full & ~dec_lane);
        wr_ok   = req_valid && req_write && !dec_bad;
        cnt_wr  = wr_ok && (dec_sel == SEL_CNT);
        gcfg_wr = wr_ok && (dec_sel == SEL_GCFG);

        for (int t = 0; t < NUM_TMR; t++) begin
            wr_cfg_v[t] = wr_ok && (dec_sel == SEL_TCFG) && (dec_tidx == IDX_W'(t));
            wr_cmp_v[t] = wr_ok && (dec_sel == SEL_TCMP) && (dec_tidx == IDX_W'(t));
            wr_rte_v[t] = wr_ok && (dec_sel == SEL_TRTE) && (dec_tidx == IDX_W'(t));
        end

        n_d = n_q;
        if (n_q.gcfg[0]) begin
            n_d.cnt = n_q.cnt + 64'd1;
        end
        if (cnt_wr) begin
            n_d.cnt = merged;
        end
        if (gcfg_wr) begin
            n_d.gcfg = keep_masked(merged, {62'h0, n_q.gcfg}, GCFG_WMASK) [1:0];
        end

        n_d.rsp_valid = req_valid;
        n_d.rsp_err   = req_valid && dec_bad;
        if (!req_valid || (req_write && !dec_bad)) begin
            n_d.rsp_data = '0;
        end else if (dec_bad) begin
            n_d.rsp_data = '1;
        end else begin
            n_d.rsp_data = (rd_full >> {dec_off, 3'b000}) & dec_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0;
        end else begin
            n_q <= n_d;
        end
    end

    assign rsp_valid = n_q.rsp_valid;
    assign rsp_err   = n_q.rsp_err;
    assign rsp_rdata = n_q.rsp_data;
    assign cnt_o     = n_q.cnt;
    assign glb_en_o  = n_q.gcfg[0];
    assign legacy_o  = n_q.gcfg[1];

    // R12: one response per request, on the next clock
    a_r12_rsp_follow: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1: a rejected access answers with error and all-ones data
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_bad) |=> (rsp_err && (rsp_rdata == '1)));

    // R8: counter holds while disabled and steps by one while enabled
    a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_o && !cnt_wr) |=> (cnt_o == $past(cnt_o)));
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_o && !cnt_wr) |=> (cnt_o == $past(cnt_o) + 64'd1));

    // R4: global bits only change on a global store
    a_r4_gcfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gcfg_wr |=> ($stable(glb_en_o) && $stable(legacy_o)));

endmodule

// File: tb/test_tmr_regfile.sv
module test_tmr_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_len = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, glb_en_o, legacy_o;
    logic [63:0] rsp_rdata, cnt_o;

    always #2 clk = ~clk;

    tmr_regfile i_tmr_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cnt_o(cnt_o), .glb_en_o(glb_en_o), .legacy_o(legacy_o)
    );

    typedef struct {
        logic [63:0] data;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [9:0] a, input logic [3:0] l,
                       input logic [63:0] d, input logic [63:0] ed, input logic ee,
                       input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_len   = l;
        req_wdata = d;
        e.data = ed;
        e.err  = ee;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic rd(input logic [9:0] a, input logic [3:0] l, input logic [63:0] ed,
                      input string tag);
        acc(1'b0, a, l, 64'h0, ed, 1'b0, tag);
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] l, input logic [63:0] d,
                      input string tag);
        acc(1'b1, a, l, d, 64'h0, 1'b0, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor: pops one expectation per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R12 response without request actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " data"}, rsp_rdata, e.data);
                check({e.tag, " err"}, {63'h0, rsp_err}, {63'h0, e.err});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
        check("R10 reset counter", cnt_o, 64'h0);
        check("R10 reset enable", {63'h0, glb_en_o}, 64'h0);
        rst_n = 1'b1;
        idle(2);

        // R6 / R2: capability word and lane extraction
        rd(10'h000, 4'd8, 64'h003D0900_8086A201, "R6 cap full");
        rd(10'h004, 4'd4, 64'h0000_0000_003D0900, "R2 cap upper word");
        rd(10'h001, 4'd1, 64'h0000_0000_0000_00A2, "R2 cap byte1");
        rd(10'h002, 4'd2, 64'h0000_0000_0000_8086, "R2 cap half1");

        // R10 / R5: reset contents
        rd(10'h010, 4'd8, 64'h0, "R10 gcfg reset");
        rd(10'h0F0, 4'd8, 64'h0, "R10 counter reset");
        rd(10'h108, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R10 cmp0 reset");
        rd(10'h130, 4'd8, 64'h0, "R10 route1 reset");
        rd(10'h120, 4'd8, 64'h00F00000_00000030, "R5 cfg1 reset");

        // R1: rejected accesses
        acc(1'b0, 10'h002, 4'd4, 64'h0, '1, 1'b1, "R1 misaligned read");
        acc(1'b0, 10'h000, 4'd3, 64'h0, '1, 1'b1, "R1 length 3");
        acc(1'b0, 10'h000, 4'd15, 64'h0, '1, 1'b1, "R1 length 15");
        acc(1'b1, 10'h109, 4'd2, 64'h0, '1, 1'b1, "R1 misaligned write");
        rd(10'h108, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R1 cmp0 untouched");

        // R9 / R7: ignored stores and zero regions
        wr(10'h000, 4'd8, 64'h0, "R9 cap store");
        rd(10'h000, 4'd8, 64'h003D0900_8086A201, "R9 cap unchanged");
        wr(10'h018, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R9 reserved store");
        rd(10'h018, 4'd8, 64'h0, "R9 reserved reads zero");
        wr(10'h160, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R9 beyond timers store");
        rd(10'h160, 4'd8, 64'h0, "R7 0x160 reads zero");
        rd(10'h3F8, 4'd8, 64'h0, "R7 top reads zero");
        rd(10'h118, 4'd8, 64'h0, "R7 timer hole reads zero");

        // R4: global mask
        wr(10'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, "R4 gcfg store");
        rd(10'h010, 4'd8, 64'h2, "R4 gcfg masked");
        idle(4);
        check("R4 legacy_o", {63'h0, legacy_o}, 64'h1);
        check("R4 glb_en_o", {63'h0, glb_en_o}, 64'h0);
        rd(10'h0F0, 4'd8, 64'h0, "R8 counter held while disabled");

        // R5 / R11: timer 0 config all ones, then 32-bit compare
        wr(10'h100, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R5 cfg0 store");
        rd(10'h100, 4'd8, 64'h00F00000_00003F7E, "R5 cfg0 masked");
        rd(10'h108, 4'd8, 64'h00000000_FFFFFFFF, "R11 cmp0 upper cleared");
        wr(10'h108, 4'd8, 64'h12345678_9ABCDEF0, "R11 cmp0 store");
        rd(10'h108, 4'd8, 64'h00000000_9ABCDEF0, "R11 cmp0 truncated");

        // R3: sub-word merges on cmp1 (64-bit mode)
        wr(10'h12B, 4'd1, 64'h55, "R3 byte store");
        rd(10'h128, 4'd8, 64'hFFFFFFFF_55FFFFFF, "R3 byte merge");
        wr(10'h12C, 4'd2, 64'h1234, "R3 half store");
        wr(10'h128, 4'd4, 64'hDEADBEEF, "R3 word store");
        rd(10'h128, 4'd8, 64'hFFFF1234_DEADBEEF, "R3 full merge");
        rd(10'h12E, 4'd2, 64'hFFFF, "R2 cmp1 top half");

        // R3 / R5: sub-word store into cfg2
        wr(10'h141, 4'd1, 64'hFF, "R3 cfg2 byte store");
        rd(10'h140, 4'd8, 64'h00F00000_00003F30, "R5 cfg2 partial masked");
        rd(10'h148, 4'd8, 64'h00000000_FFFFFFFF, "R11 cmp2 upper cleared");

        // R7: route word
        wr(10'h110, 4'd8, 64'hA5A5A5A5_A5A5A5A5, "R7 route0 store");
        wr(10'h114, 4'd4, 64'h11223344, "R7 route0 upper store");
        rd(10'h110, 4'd8, 64'h11223344_A5A5A5A5, "R7 route0 read");

        // R8: counting over a known window
        wr(10'h010, 4'd8, 64'h0, "R8 disable");
        wr(10'h0F0, 4'd8, 64'h100, "R8 counter preset");
        wr(10'h010, 4'd1, 64'h01, "R8 enable");
        idle(9);
        wr(10'h010, 4'd8, 64'h0, "R8 disable again");
        rd(10'h0F0, 4'd8, 64'h10A, "R8 ten increments");

        // R8: store while counting wins
        wr(10'h010, 4'd8, 64'h3, "R4 enable and legacy");
        wr(10'h0F0, 4'd8, 64'h5000, "R8 store while enabled");
        rd(10'h0F0, 4'd8, 64'h5000, "R8 store taken");
        rd(10'h0F0, 4'd8, 64'h5001, "R8 next count");
        rd(10'h0F4, 4'd4, 64'h0, "R2 counter upper word");
        wr(10'h010, 4'd8, 64'h0, "R8 final disable");
        idle(4);
        check("R8 counter stopped", cnt_o, 64'h5004);
        check("R4 enable cleared", {63'h0, glb_en_o}, 64'h0);

        idle(3);
        check("R12 all responses seen", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule